// File: doc/BRIEF.md
# Calorimeter Trigger Primitive Pipeline

This block turns the raw 7-bit sample that one calorimeter channel delivers on every bunch crossing into an 8-bit trigger primitive. One result leaves per clock at the crossing rate. First, a writable lookup converts each raw sample to a 10-bit transverse energy. The energy of each crossing is then added to the energy of the crossing before it. A peak finder on these two-sample sums gives each pulse to exactly one crossing, and every other crossing of the pulse reports zero energy. A second writable lookup compresses the surviving 10-bit sum into a 7-bit code.

A muon flag travels beside the energy. It comes from a one-bit window lookup on the raw sample and is delayed to line up with the peak decision. It is cleared in two cases: when a no-shower lookup, indexed by the summed energy, marks the sum as leakage from a shower, and when the crossing lies on the falling tail of a larger pulse. A bypass control skips the peak filter and the tail veto. A mask control forces the primitive to zero. All four lookups share one write port, which is meant to be used while the input is held idle.

Top module: `tpg_pipeline`

## Requirements
- R1: While `rst` is high, `tp_out` is 0. After reset it stays 0 until a nonzero linearized energy reaches the output, because all pipeline history restarts at zero energy.
- R2: The energy of crossing k is E(k) = LIN[x(k)], a 10-bit value in 0.5 GeV units taken from the linearization table at the raw sample x(k).
- R3: The summed energy is S(k) = E(k) + E(k-1), saturated at 1023.
- R4: Crossing k is a peak when S(k) > S(k-1) and S(k) >= S(k+1). Without bypass, a non-peak crossing gives `tp_out[6:0]` = 0.
- R5: At a peak crossing, `tp_out[6:0]` = CMP[S(k)], the 7-bit entry of the compression table at the 10-bit sum.
- R6: `tp_out[7]` (muon flag) is MUW[x(k)] AND NOT NSH[S(k)[9:3]]. Here MUW is the muon-window table and NSH is the no-shower table, and a 1 in NSH vetoes the flag.
- R7: Without bypass, the muon flag is also cleared when S(k-1) > S(k), which marks the tail of a more energetic event.
- R8: With `bypass_en` high at the output edge, `tp_out[6:0]` = CMP[S(k)] for every crossing, and the tail veto is not applied.
- R9: With `mask_en` high at the output edge, `tp_out` is 0, whatever the other inputs are.
- R10: A sample is captured at a rising edge, and its primitive is registered exactly 3 rising edges later. `bypass_en` and `mask_en` act at that output edge.
- R11: A write with `lut_we`=1 updates one table at the next edge. `lut_sel` picks the table: 0 = linearization (addr[6:0], data[9:0]), 1 = muon window (addr[6:0], data[0]), 2 = no-shower (addr[6:0], data[0]), 3 = compression (addr[9:0], data[6:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline registers |
| sample_in | input | 7 | Raw sample for the current crossing |
| bypass_en | input | 1 | Skip peak filtering and the tail veto |
| mask_en | input | 1 | Force the primitive to zero |
| lut_we | input | 1 | Table write strobe |
| lut_sel | input | 2 | Table select for the write |
| lut_addr | input | 10 | Table write address |
| lut_wdata | input | 10 | Table write data (low bits used for narrow tables) |
| tp_out | output | 8 | Trigger primitive: bit 7 muon flag, bits 6:0 compressed energy |

## Verification
The bench covers the following corner cases:
- **Plateau of equal sums.** A design that used >= on both sides of the peak compare would report the pulse twice.
- **Two saturated neighbours.** A design that let the sum wrap instead of clamping would report a small energy and place the peak wrongly.
- **Muon-window sample on a falling tail, and one under a no-shower entry.** A design with a misaligned or missing veto would keep the flag set.
- **Bypass and mask runs inside a random stream, and a compression entry rewritten while idle.** These would expose energy that is still gated by the peak finder, a mask that acts one crossing late, or a write that never lands. Any shift of the latency away from three edges fails every per-cycle compare.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [1:0] {
    LUT_LIN      = 2'd0,
    LUT_MUWIN    = 2'd1,
    LUT_NOSHOWER = 2'd2,
    LUT_COMP     = 2'd3
  } lut_sel_e;

  localparam int unsigned TP_LATENCY = 3;

endpackage

// File: rtl/tpg_lut.sv
module tpg_lut #(
  parameter int AW = 7,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/tpg_delay.sv
module tpg_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int SRW = W * DEPTH;

  logic [SRW-1:0] sr;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[SRW-W-1:0], d};
      end
    end
  endgenerate

  assign q = sr[SRW-1 -: W];

endmodule

// File: rtl/tpg_sum_peak.sv
module tpg_sum_peak #(
  parameter int ET_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ET_W-1:0] et_in,
  output logic [ET_W-1:0] sum_cur,
  output logic            peak_w,
  output logic            trail_w
);
  localparam logic [ET_W-1:0] ET_MAX = '1;

  function automatic logic [ET_W-1:0] sat_add(input logic [ET_W-1:0] a,
                                               input logic [ET_W-1:0] b);
    logic [ET_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ET_W] ? ET_MAX : s[ET_W-1:0];
  endfunction

  function automatic logic is_peak(input logic [ET_W-1:0] prv,
                                   input logic [ET_W-1:0] cur,
                                   input logic [ET_W-1:0] nxt);
    return (cur > prv) && (cur >= nxt);
  endfunction

  logic [ET_W-1:0] et_q, et_d;
  logic [ET_W-1:0] sum_nx, sum_cu, sum_pv;

  always_ff @(posedge clk) begin
    if (rst) begin
      et_q   <= '0;
      et_d   <= '0;
      sum_nx <= '0;
      sum_cu <= '0;
      sum_pv <= '0;
    end else begin
      et_q   <= et_in;
      et_d   <= et_q;
      sum_nx <= sat_add(et_q, et_d);
      sum_cu <= sum_nx;
      sum_pv <= sum_cu;
    end
  end

  assign sum_cur = sum_cu;
  assign peak_w  = is_peak(sum_pv, sum_cu, sum_nx);
  assign trail_w = sum_pv > sum_cu;

  AST_PEAK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    peak_w |=> !peak_w); // R4

  AST_PEAK_NOT_TRAIL: assert property (@(posedge clk) disable iff (rst)
    peak_w |-> !trail_w); // R7

endmodule

// File: rtl/tpg_out_stage.sv
module tpg_out_stage #(
  parameter int CMP_W = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CMP_W-1:0] cmp_in,
  input  logic           peak,
  input  logic           trail,
  input  logic           mu_al,
  input  logic           ns_veto,
  input  logic           bypass,
  input  logic           mask,
  output logic [CMP_W:0] tp_out
);
  logic [CMP_W:0]   tp_q;
  logic [CMP_W-1:0] en_sel;
  logic             mu_sel;

  always_comb begin
    en_sel = (bypass || peak) ? cmp_in : '0;
    mu_sel = mu_al && !ns_veto && (bypass || !trail);
  end

  always_ff @(posedge clk) begin
    if (rst)       tp_q <= '0;
    else if (mask) tp_q <= '0;
    else           tp_q <= {mu_sel, en_sel};
  end

  assign tp_out = tp_q;

  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    mask |=> (tp_out == '0)); // R9

  AST_NONPEAK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!mask && !bypass && !peak) |=> (tp_out[CMP_W-1:0] == '0)); // R4

  AST_TRAIL_NO_MUON: assert property (@(posedge clk) disable iff (rst)
    (!bypass && trail) |=> !tp_out[CMP_W]); // R7

  AST_NS_VETO: assert property (@(posedge clk) disable iff (rst)
    ns_veto |=> !tp_out[CMP_W]); // R6

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    (bypass && !mask) |=> (tp_out[CMP_W-1:0] == $past(cmp_in))); // R8

endmodule

// File: rtl/tpg_pipeline.sv
module tpg_pipeline
  import tpg_pkg::*;
#(
  parameter int RAW_W = 7,
  parameter int ET_W  = 10,
  parameter int CMP_W = 7,
  parameter int NS_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RAW_W-1:0] sample_in,
  input  logic             bypass_en,
  input  logic             mask_en,
  input  logic             lut_we,
  input  logic [1:0]       lut_sel,
  input  logic [ET_W-1:0]  lut_addr,
  input  logic [ET_W-1:0]  lut_wdata,
  output logic [CMP_W:0]   tp_out
);
  localparam int MU_DEPTH = TP_LATENCY;

  logic we_lin, we_mu, we_ns, we_cmp;
  logic [ET_W-1:0]  lin_rd;
  logic             mu_rd, mu_al, ns_rd;
  logic [ET_W-1:0]  sum_cur;
  logic             peak_w, trail_w;
  logic [CMP_W-1:0] cmp_rd;

  assign we_lin = lut_we && (lut_sel == LUT_LIN);
  assign we_mu  = lut_we && (lut_sel == LUT_MUWIN);
  assign we_ns  = lut_we && (lut_sel == LUT_NOSHOWER);
  assign we_cmp = lut_we && (lut_sel == LUT_COMP);

  tpg_lut #(.AW(RAW_W), .DW(ET_W)) u_lin (
    .clk(clk), .we(we_lin), .waddr(lut_addr[RAW_W-1:0]), .wdata(lut_wdata),
    .raddr(sample_in), .rdata(lin_rd));

  tpg_lut #(.AW(RAW_W), .DW(1)) u_muwin (
    .clk(clk), .we(we_mu), .waddr(lut_addr[RAW_W-1:0]), .wdata(lut_wdata[0]),
    .raddr(sample_in), .rdata(mu_rd));

  tpg_sum_peak #(.ET_W(ET_W)) u_sum (
    .clk(clk), .rst(rst), .et_in(lin_rd),
    .sum_cur(sum_cur), .peak_w(peak_w), .trail_w(trail_w));

  tpg_delay #(.W(1), .DEPTH(MU_DEPTH)) u_mu_dly (
    .clk(clk), .rst(rst), .d(mu_rd), .q(mu_al));

  tpg_lut #(.AW(NS_W), .DW(1)) u_noshower (
    .clk(clk), .we(we_ns), .waddr(lut_addr[NS_W-1:0]), .wdata(lut_wdata[0]),
    .raddr(sum_cur[ET_W-1 -: NS_W]), .rdata(ns_rd));

  tpg_lut #(.AW(ET_W), .DW(CMP_W)) u_comp (
    .clk(clk), .we(we_cmp), .waddr(lut_addr), .wdata(lut_wdata[CMP_W-1:0]),
    .raddr(sum_cur), .rdata(cmp_rd));

  tpg_out_stage #(.CMP_W(CMP_W)) u_out (
    .clk(clk), .rst(rst), .cmp_in(cmp_rd), .peak(peak_w), .trail(trail_w),
    .mu_al(mu_al), .ns_veto(ns_rd), .bypass(bypass_en), .mask(mask_en),
    .tp_out(tp_out));

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (tp_out == '0)); // R1

endmodule

// File: tb/sim_tpg_pipeline.sv
module sim_tpg_pipeline;
  localparam int CLK_NS = 25;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] sample_in = '0;
  logic       bypass_en = 1'b0;
  logic       mask_en = 1'b0;
  logic       lut_we = 1'b0;
  logic [1:0] lut_sel = '0;
  logic [9:0] lut_addr = '0;
  logic [9:0] lut_wdata = '0;
  logic [7:0] tp_out;

  tpg_pipeline u0 (
    .clk(clk), .rst(rst), .sample_in(sample_in), .bypass_en(bypass_en),
    .mask_en(mask_en), .lut_we(lut_we), .lut_sel(lut_sel), .lut_addr(lut_addr),
    .lut_wdata(lut_wdata), .tp_out(tp_out));

  always #(CLK_NS/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit cmp_on = 0;

  int lin_m [128];
  int mu_m  [128];
  int ns_m  [128];
  int comp_m[1024];

  int eh[6];
  int mh[4];
  int sp, sc, sn, exp_en, exp_mu;
  bit pk, tr, nsv, satf;
  string etag = "R1";
  string mtag = "R1";

  function automatic int sat(input int v);
    return (v > 1023) ? 1023 : v;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Behavioural reference: history of energies and window bits per crossing
  always @(posedge clk) begin
    if (rst) begin
      foreach (eh[i]) eh[i] = 0;
      foreach (mh[i]) mh[i] = 0;
      exp_en = 0; exp_mu = 0; etag = "R1"; mtag = "R1";
    end else begin
      for (int i = 5; i > 0; i--) eh[i] = eh[i-1];
      eh[0] = lin_m[sample_in];
      for (int i = 3; i > 0; i--) mh[i] = mh[i-1];
      mh[0] = mu_m[sample_in];
      sn = sat(eh[2] + eh[3]);
      sc = sat(eh[3] + eh[4]);
      sp = sat(eh[4] + eh[5]);
      satf = (eh[3] + eh[4]) > 1023;
      pk = (sc > sp) && (sc >= sn);
      tr = sp > sc;
      nsv = ns_m[sc / 8] != 0;
      exp_en = (bypass_en || pk) ? comp_m[sc] : 0;
      exp_mu = (mh[3] != 0 && !nsv && (bypass_en || !tr)) ? 1 : 0;
      if (mask_en) begin exp_en = 0; exp_mu = 0; end
      etag = mask_en ? "R9" : bypass_en ? "R8" : !pk ? "R4" : satf ? "R3" : "R5";
      mtag = mask_en ? "R9" : nsv ? "R6" : (tr && !bypass_en) ? "R7" : "R6";
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(etag, "energy", int'(tp_out[6:0]), exp_en);
      chk(mtag, "muon", int'(tp_out[7]), exp_mu);
    end
  end

  task automatic wr(input int sel, input int addr, input int data);
    @(negedge clk);
    lut_we = 1'b1; lut_sel = 2'(sel); lut_addr = 10'(addr); lut_wdata = 10'(data);
    case (sel)
      0: lin_m[addr] = data;
      1: mu_m[addr] = data & 1;
      2: ns_m[addr] = data & 1;
      default: comp_m[addr] = data & 127;
    endcase
    @(negedge clk);
    lut_we = 1'b0;
  endtask

  task automatic drive(input int raw, input bit byp, input bit msk);
    @(negedge clk);
    sample_in = 7'(raw); bypass_en = byp; mask_en = msk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0);
  endtask

  // Isolated sample: output registered on the third edge after capture (R10)
  task automatic impulse(input int raw, input string tag);
    int e;
    e = lin_m[raw];
    drive(raw, 0, 0);
    @(negedge clk); sample_in = '0;
    chk(tag, "pre-latency edge0", int'(tp_out), 0);
    @(negedge clk);
    chk(tag, "pre-latency edge1", int'(tp_out), 0);
    @(negedge clk);
    chk(tag, "pre-latency edge2", int'(tp_out), 0);
    @(negedge clk);
    chk(tag, "latency edge3", int'(tp_out),
        ((mu_m[raw] != 0 && ns_m[e / 8] == 0) ? 128 : 0) + comp_m[e]);
    idle(4);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      lin_m[i] = (i == 127) ? 1000 : (i == 126) ? 900 : i * 8;
      mu_m[i]  = (i >= 10 && i <= 20) ? 1 : 0;
      ns_m[i]  = (i >= 120) ? 1 : 0;
    end
    for (int s = 0; s < 1024; s++) comp_m[s] = (s * 37 + 11) % 128;

    @(posedge clk);
    cmp_on = 1;
    // R11: tables loaded through the write port while the pipeline is held in reset
    for (int i = 0; i < 128; i++) wr(0, i, lin_m[i]);
    for (int i = 0; i < 128; i++) wr(1, i, mu_m[i]);
    for (int i = 0; i < 128; i++) wr(2, i, ns_m[i]);
    for (int s = 0; s < 1024; s++) wr(3, s, comp_m[s]);
    @(negedge clk);
    chk("R1", "reset output", int'(tp_out), 0);
    rst = 1'b0;
    idle(4);
    chk("R1", "post-reset output", int'(tp_out), 0);

    impulse(50, "R10");
    impulse(30, "R2");
    impulse(15, "R6");

    for (int i = 0; i < 127; i += 9) drive(i, 0, 0);      // ramp
    idle(4);
    for (int i = 0; i < 5; i++) drive(40, 0, 0);          // plateau, R4
    idle(4);
    for (int i = 0; i < 3; i++) drive(127, 0, 0);         // saturation, R3
    idle(4);
    drive(100, 0, 0); drive(60, 0, 0); drive(15, 0, 0);   // tail muon, R7
    idle(4);
    drive(120, 0, 0); drive(12, 0, 0);                    // no-shower veto, R6
    idle(4);
    drive(100, 1, 0); drive(60, 1, 0); drive(15, 1, 0);   // bypass, R8
    drive(0, 1, 0); drive(0, 1, 0);
    idle(4);
    drive(50, 0, 0); drive(14, 0, 0); drive(0, 0, 0);
    drive(0, 0, 1); drive(0, 0, 1);                       // mask, R9
    idle(4);

    // R11: rewrite one compression entry while idle, then reuse it
    wr(3, 400, 5);
    idle(2);
    impulse(50, "R11");

    begin
      int unsigned st;
      st = 32'h1234_5678;
      for (int i = 0; i < 1500; i++) begin
        st = st * 32'd1664525 + 32'd1013904223;
        drive(int'(st[30:24]), st[11:8] == 4'd0, st[15:12] == 4'd0);
      end
    end
    idle(6);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule